// File: doc/BRIEF.md
# Dual Programmable-Length Video Line Delay

The block holds two independent 12-bit delay channels, A and B. Each channel captures its input in a register and writes it into a RAM ring. The ring is addressed by separate write and read pointers and read through an output register. A length register, loaded from a length bus that both channels share, sets each channel's input-to-output delay to the loaded value plus two clock cycles. This makes each channel a delay of up to one video line, or a fixed pipeline skew, that can be programmed.

A channel runs as a plain delay while its hold input is low. Raising hold freezes the ring: nothing is written and the write pointer stops, while the read pointer keeps turning. The channel therefore replays the last stored stretch of samples over and over. A 2-bit mode input can chain the channels so that B stores A's output in place of its own data input, and the two delays add up. Each channel has its own clock, its own active-low length-load strobe and its own active-low write-pointer and read-pointer resets. The pointers have no defined state at power-up, so both resets must be pulsed together before the outputs mean anything, and again after hold is released. Cascaded operation assumes both channel clocks are the same clock.

Top module: `dual_line_delay`

## Requirements
- R1: After a channel's two pointer resets are released at the same clock edge, and with hold low, a sample captured at clock edge e appears on that channel's output right after edge e+L+2, where L is the channel's loaded length.
- R2: A channel's length register takes the value on the length bus at a rising edge where that channel's load strobe is low. At every other edge it keeps its value, whatever the bus carries, and loading one channel leaves the other channel's delay unchanged.
- R3: While hold is high, the channel writes nothing and its write pointer does not move, so the data input is ignored. The output keeps replaying the stored samples with a period of L+1 cycles.
- R4: A low write-pointer reset sends the write pointer to location 0 and suppresses the write at that edge. A low read-pointer reset sends the read pointer to location 0. Both resets take priority over hold.
- R5: Both pointers return to location 0 after location L, so the ring in use holds L+1 words. The delay of R1 stays exact across many trips around the ring.
- R6: With mode 2'b01 (cascade), channel B stores channel A's registered output in place of b_din. A sample entering A then leaves B after LA+2+LB+2 cycles.
- R7: With mode 2'b00, 2'b10 or 2'b11, the channels are independent and channel B delays b_din.
- R8: Length 0 gives a 2-cycle delay. The largest length, 2^LEN_W-1 (1023 by default), gives a delay of 2^LEN_W+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Channel A clock, rising edge |
| clk_b | input | 1 | Channel B clock, rising edge |
| mode | input | 2 | Arrangement select; 2'b01 cascades A into B |
| length | input | LEN_W | Shared length bus, delay minus two |
| a_ld_n | input | 1 | Active-low length load, channel A |
| b_ld_n | input | 1 | Active-low length load, channel B |
| a_din | input | DW | Channel A data input |
| b_din | input | DW | Channel B data input (unused when cascaded) |
| a_hold | input | 1 | Channel A recirculate (high) / delay (low) |
| b_hold | input | 1 | Channel B recirculate (high) / delay (low) |
| a_rw_n | input | 1 | Active-low write-pointer reset, channel A |
| a_rr_n | input | 1 | Active-low read-pointer reset, channel A |
| b_rw_n | input | 1 | Active-low write-pointer reset, channel B |
| b_rr_n | input | 1 | Active-low read-pointer reset, channel B |
| a_dout | output | DW | Channel A registered output |
| b_dout | output | DW | Channel B registered output |

## Verification
Three pairs of functions can act at the same clock edge. A pointer reset can coincide with a length load, a pointer reset can arrive while hold is still high, and a cascaded write into B can take place while A is replaying its ring. The bench sets up every configuration with the length load and the pointer resets at the same edge. It also leaves channel A's hold high across a reset pulse, so that reset priority and the suppressed write are both exercised, and it runs cascade with random data. Each case is judged cycle by cycle against a reference model built from the requirements. The model tracks write flags, restart edges and ring sizes for each edge.

// File: rtl/dld_pkg.sv
package dld_pkg;

    typedef enum logic [1:0] {
        MODE_DUAL    = 2'b00,
        MODE_CASCADE = 2'b01,
        MODE_QUEUE   = 2'b10,
        MODE_SPARE   = 2'b11
    } dld_mode_e;

    // Only the cascade code changes the data path; every other code runs
    // the two channels side by side.
    function automatic logic mode_is_cascade(input logic [1:0] code);
        return code == MODE_CASCADE;
    endfunction

endpackage

// File: rtl/dld_ptr.sv
module dld_ptr #(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             step,
    input  logic [LEN_W-1:0] last,
    output logic [LEN_W-1:0] ptr
);
    localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [LEN_W-1:0] pos;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!clr_n) begin
            st_d.pos = '0;
        end else if (step) begin
            // wrap at or beyond the ring end so a shrunk length recovers
            if (st_q.pos >= last) begin
                st_d.pos = '0;
            end else begin
                st_d.pos = st_q.pos + ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ptr = st_q.pos;

endmodule

// File: rtl/dld_ring.sv
module dld_ring #(
    parameter int DW = 12,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_d, rd_q;

    // read sees the word before any write at the same edge
    always_comb begin
        rd_d = mem[raddr];
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rd_q <= rd_d;
    end

    assign rdata = rd_q;

endmodule

// File: rtl/dld_chan.sv
module dld_chan #(
    parameter int DW    = 12,
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             ld_n,
    input  logic [LEN_W-1:0] len_in,
    input  logic [DW-1:0]    din,
    input  logic [DW-1:0]    alt_din,
    input  logic             use_alt,
    input  logic             hold,
    input  logic             rw_n,
    input  logic             rr_n,
    output logic [DW-1:0]    dout
);
    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [DW-1:0]    smp;
    } chan_st_t;

    chan_st_t st_d, st_q;

    logic [LEN_W-1:0] wr_ptr;
    logic [LEN_W-1:0] rd_ptr;
    logic [LEN_W-1:0] len_cur;
    logic [DW-1:0]    wr_data;
    logic             wr_en;

    always_comb begin
        st_d     = st_q;
        st_d.smp = din;
        if (!ld_n) begin
            st_d.len = len_in;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign len_cur = st_q.len;
    assign wr_data = use_alt ? alt_din : st_q.smp;
    assign wr_en   = rw_n & ~hold;

    dld_ptr #(.LEN_W(LEN_W)) u_wptr (
        .clk   (clk),
        .clr_n (rw_n),
        .step  (~hold),
        .last  (len_cur),
        .ptr   (wr_ptr)
    );

    dld_ptr #(.LEN_W(LEN_W)) u_rptr (
        .clk   (clk),
        .clr_n (rr_n),
        .step  (1'b1),
        .last  (len_cur),
        .ptr   (rd_ptr)
    );

    dld_ring #(.DW(DW), .AW(LEN_W)) u_ring (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .raddr (rd_ptr),
        .rdata (dout)
    );

endmodule

// File: rtl/dual_line_delay.sv
module dual_line_delay
    import dld_pkg::*;
#(
    parameter int DW    = 12,
    parameter int LEN_W = 10
) (
    input  logic             clk_a,
    input  logic             clk_b,
    input  logic [1:0]       mode,
    input  logic [LEN_W-1:0] length,
    input  logic             a_ld_n,
    input  logic             b_ld_n,
    input  logic [DW-1:0]    a_din,
    input  logic [DW-1:0]    b_din,
    input  logic             a_hold,
    input  logic             b_hold,
    input  logic             a_rw_n,
    input  logic             a_rr_n,
    input  logic             b_rw_n,
    input  logic             b_rr_n,
    output logic [DW-1:0]    a_dout,
    output logic [DW-1:0]    b_dout
);
    logic          cascade;
    logic [DW-1:0] a_out_int;

    assign cascade = mode_is_cascade(mode);

    dld_chan #(.DW(DW), .LEN_W(LEN_W)) u_ch_a (
        .clk     (clk_a),
        .ld_n    (a_ld_n),
        .len_in  (length),
        .din     (a_din),
        .alt_din ('0),
        .use_alt (1'b0),
        .hold    (a_hold),
        .rw_n    (a_rw_n),
        .rr_n    (a_rr_n),
        .dout    (a_out_int)
    );

    dld_chan #(.DW(DW), .LEN_W(LEN_W)) u_ch_b (
        .clk     (clk_b),
        .ld_n    (b_ld_n),
        .len_in  (length),
        .din     (b_din),
        .alt_din (a_out_int),
        .use_alt (cascade),
        .hold    (b_hold),
        .rw_n    (b_rw_n),
        .rr_n    (b_rr_n),
        .dout    (b_dout)
    );

    assign a_dout = a_out_int;

endmodule

// File: rtl/dld_checker.sv
module dld_checker #(
    parameter int LEN_W = 10
) (
    input logic             clk,
    input logic             rw_n,
    input logic             rr_n,
    input logic             hold,
    input logic             ld_n,
    input logic [LEN_W-1:0] len_bus,
    input logic [LEN_W-1:0] wptr,
    input logic [LEN_W-1:0] rptr,
    input logic [LEN_W-1:0] len
);
    // pointers mean nothing until both resets have been seen together
    logic armed;
    always_ff @(posedge clk) begin
        if (!rw_n && !rr_n) begin
            armed <= 1'b1;
        end
    end

    a_r4_wptr_home: assert property (@(posedge clk) disable iff (!armed)
        !rw_n |=> wptr == '0);

    a_r4_rptr_home: assert property (@(posedge clk) disable iff (!armed)
        !rr_n |=> rptr == '0);

    a_r3_wptr_frozen: assert property (@(posedge clk) disable iff (!armed)
        (rw_n && hold) |=> wptr == $past(wptr));

    a_r2_len_capture: assert property (@(posedge clk) disable iff (!armed)
        !ld_n |=> len == $past(len_bus));

    a_r2_len_keep: assert property (@(posedge clk) disable iff (!armed)
        ld_n |=> len == $past(len));

    a_r1_ptrs_locked: assert property (@(posedge clk) disable iff (!armed)
        (rw_n && rr_n && !hold && wptr == rptr) |=> wptr == rptr);

endmodule

bind dual_line_delay dld_checker #(.LEN_W(LEN_W)) u_chk_a (
    .clk     (clk_a),
    .rw_n    (a_rw_n),
    .rr_n    (a_rr_n),
    .hold    (a_hold),
    .ld_n    (a_ld_n),
    .len_bus (length),
    .wptr    (u_ch_a.wr_ptr),
    .rptr    (u_ch_a.rd_ptr),
    .len     (u_ch_a.len_cur)
);

bind dual_line_delay dld_checker #(.LEN_W(LEN_W)) u_chk_b (
    .clk     (clk_b),
    .rw_n    (b_rw_n),
    .rr_n    (b_rr_n),
    .hold    (b_hold),
    .ld_n    (b_ld_n),
    .len_bus (length),
    .wptr    (u_ch_b.wr_ptr),
    .rptr    (u_ch_b.rd_ptr),
    .len     (u_ch_b.len_cur)
);

// File: tb/sim_dual_line_delay.sv
module sim_dual_line_delay;
    localparam int DW    = 12;
    localparam int LEN_W = 10;
    localparam int H     = 4096;
    localparam int NV    = 6;

    // configuration table: length A, length B, mode, requirement group
    localparam int V_LA [NV] = '{0, 5, 3, 7, 1, 1023};
    localparam int V_LB [NV] = '{0, 13, 4, 2, 9, 1};
    localparam int V_MD [NV] = '{0, 0, 1, 2, 3, 0};
    localparam int V_RQ [NV] = '{8, 1, 6, 7, 7, 8};

    logic             clk = 1'b0;
    logic [1:0]       mode = 2'b00;
    logic [LEN_W-1:0] length = '0;
    logic             a_ld_n = 1'b1, b_ld_n = 1'b1;
    logic [DW-1:0]    a_din = '0, b_din = '0;
    logic             a_hold = 1'b0, b_hold = 1'b0;
    logic             a_rw_n = 1'b1, a_rr_n = 1'b1, b_rw_n = 1'b1, b_rr_n = 1'b1;
    logic [DW-1:0]    a_dout, b_dout;

    always #4 clk = ~clk;

    dual_line_delay #(.DW(DW), .LEN_W(LEN_W)) u0 (
        .clk_a(clk), .clk_b(clk), .mode(mode), .length(length),
        .a_ld_n(a_ld_n), .b_ld_n(b_ld_n), .a_din(a_din), .b_din(b_din),
        .a_hold(a_hold), .b_hold(b_hold), .a_rw_n(a_rw_n), .a_rr_n(a_rr_n),
        .b_rw_n(b_rw_n), .b_rr_n(b_rr_n), .a_dout(a_dout), .b_dout(b_dout)
    );

    // reference history, indexed by edge number modulo H
    logic [DW-1:0] a_in_h [H];
    logic [DW-1:0] b_in_h [H];
    logic [DW-1:0] ea_h   [H];
    logic [DW-1:0] eb_h   [H];
    bit            a_wr_h [H];
    bit            b_wr_h [H];
    bit            cas_h  [H];
    bit            eav_h  [H];
    bit            ebv_h  [H];

    int    n = 0;
    int    ring_a = 1, ring_b = 1;
    int    start_a = 1 << 30, start_b = 1 << 30;
    bit    chk_on = 1'b1;
    bit    done = 1'b0;
    string tag = "R1";
    int    checks = 0, fails = 0;

    task automatic compare(input string ch, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s channel %s edge %0d: got %h expected %h", tag, ch, n, got, exp);
        end
    endtask

    task automatic tick();
        int idx, ka, kb;
        @(posedge clk);
        n++;
        idx = n % H;
        a_in_h[idx] = a_din;
        b_in_h[idx] = b_din;
        a_wr_h[idx] = a_rw_n && !a_hold;
        b_wr_h[idx] = b_rw_n && !b_hold;
        cas_h[idx]  = (mode == 2'b01);
        if (!a_rw_n) start_a = n + 1;
        if (!b_rw_n) start_b = n + 1;
        // channel A: read at edge n returns what was written R edges earlier
        ka = n - ring_a;
        eav_h[idx] = 1'b0;
        if (ka >= start_a) begin
            if (a_wr_h[ka % H]) begin
                ea_h[idx]  = a_in_h[(ka - 1) % H];
                eav_h[idx] = 1'b1;
            end else begin
                ea_h[idx]  = ea_h[ka % H];
                eav_h[idx] = eav_h[ka % H];
            end
        end
        kb = n - ring_b;
        ebv_h[idx] = 1'b0;
        if (kb >= start_b) begin
            if (b_wr_h[kb % H]) begin
                if (cas_h[kb % H]) begin
                    eb_h[idx]  = ea_h[(kb - 1) % H];
                    ebv_h[idx] = eav_h[(kb - 1) % H];
                end else begin
                    eb_h[idx]  = b_in_h[(kb - 1) % H];
                    ebv_h[idx] = 1'b1;
                end
            end else begin
                eb_h[idx]  = eb_h[kb % H];
                ebv_h[idx] = ebv_h[kb % H];
            end
        end
        if (!a_ld_n) ring_a = int'(length) + 1;
        if (!b_ld_n) ring_b = int'(length) + 1;
        @(negedge clk);
        if (chk_on) begin
            if (eav_h[idx]) compare("A", a_dout, ea_h[idx]);
            if (ebv_h[idx]) compare("B", b_dout, eb_h[idx]);
        end
    endtask

    task automatic drive_rand();
        a_din  = DW'($urandom());
        b_din  = DW'($urandom());
        length = LEN_W'($urandom());   // ignored while both strobes are high (R2)
    endtask

    task automatic stream(input int cyc);
        for (int i = 0; i < cyc; i++) begin
            drive_rand();
            tick();
        end
    endtask

    // length load and pointer resets share an edge on purpose
    task automatic setup(input int la, input int lb, input logic [1:0] md);
        mode = md;
        drive_rand();
        length = LEN_W'(la);
        a_ld_n = 1'b0; a_rw_n = 1'b0; a_rr_n = 1'b0; b_rw_n = 1'b0; b_rr_n = 1'b0;
        tick();
        drive_rand();
        length = LEN_W'(lb);
        a_ld_n = 1'b1; b_ld_n = 1'b0;
        tick();
        b_ld_n = 1'b1;
        a_rw_n = 1'b1; a_rr_n = 1'b1; b_rw_n = 1'b1; b_rr_n = 1'b1;
    endtask

    function automatic string grp(input int r);
        case (r)
            1: return "R1 R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        // table walk
        for (int v = 0; v < NV; v++) begin
            tag = grp(V_RQ[v]);
            setup(V_LA[v], V_LB[v], 2'(V_MD[v]));
            stream(3 * (V_LA[v] + V_LB[v] + 4) + 20);
        end

        // R3: freeze channel A and watch the replay, B keeps delaying
        tag = "R3";
        setup(6, 10, 2'b00);
        stream(30);
        a_hold = 1'b1;
        stream(40);

        // R4: resets while hold is still high, then release both
        tag = "R4";
        a_rw_n = 1'b0; a_rr_n = 1'b0;
        drive_rand();
        tick();
        a_rw_n = 1'b1; a_rr_n = 1'b1; a_hold = 1'b0;
        stream(30);

        // R4: misalign the pointers unchecked, then realign with both resets
        chk_on = 1'b0;
        a_rw_n = 1'b0;
        drive_rand();
        tick();
        a_rw_n = 1'b1;
        stream(20);
        chk_on = 1'b1;
        a_rw_n = 1'b0; a_rr_n = 1'b0;
        drive_rand();
        tick();
        a_rw_n = 1'b1; a_rr_n = 1'b1;
        stream(30);

        // R2: reload only channel A; B must keep its delay of 12
        tag = "R2";
        drive_rand();
        length = LEN_W'(2);
        a_ld_n = 1'b0; a_rw_n = 1'b0; a_rr_n = 1'b0;
        tick();
        a_ld_n = 1'b1; a_rw_n = 1'b1; a_rr_n = 1'b1;
        stream(40);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL %s watchdog: got timeout expected completion", tag);
            summary();
            $finish;
        end
    end

endmodule